// File: doc/BRIEF.md
# Six-Channel Chainable Down-Counter Bank

The block holds six independent 8-bit down counters, each paired with a reload latch, a source selector and a sticky interrupt request bit. Every counter divides its chosen count source by (n+1), where n is the value in its latch. Each counter raises a one-cycle overflow pulse and sets its request bit when it wraps. A controller writes the latches and two source-select mode registers through a small strobe port. It clears request bits by writing ones to a clear strobe.

Every count source is a single-cycle enable in the block's clock domain. The fast and slow base tick inputs feed a free-running prescaler, and one select bit decides which of the two feeds it. The prescaler supplies divide-by-2, divide-by-16 and divide-by-4096 taps. Two external pins are synchronised, and each of their falling edges counts once. Several counters can take the overflow of a lower-numbered counter as their source, so that counter acts as a prescaler for the next one. An overflow passes down such a chain within the same clock cycle.

Top module: `timer_bank`

## Requirements
- R1: After reset, all counters, latches, mode fields and request bits are zero, the external-pin synchronisers hold the idle-high level, and `ovf_o` and `irq_o` are both zero.
- R2: A write with `lat_we_i` high and `lat_idx_i` = k (0..5 selects counter k+1) loads `wr_data_i` into that counter's latch and its live counter in the same cycle. A count pulse for that counter in the write cycle is dropped. Index values 6 and 7 are ignored.
- R3: Each count pulse decrements a non-zero counter by one, so a steady source is divided by n+1, where n is the latch value.
- R4: A count pulse that finds the counter at 00h produces a one-cycle pulse on that counter's bit of `ovf_o` in that same cycle and reloads the counter from its latch.
- R5: `base_sel_i` = 0 drives the prescaler from `fast_tick_i`; `base_sel_i` = 1 drives it from `slow_tick_i`.
- R6: The prescaler advances once per base tick. It gives the /2 tap on every second base tick, the /16 tap on every sixteenth and the /4096 tap on every 4096th.
- R7: Mode register 0 (`mode_idx_i` = 0) bits [1:0] pick counter 1's source: 0 = /16, 1 = /4096, 2 or 3 = pin 0. Bits [3:2] pick counter 2's source: 0 = /16, 1 = counter 1 overflow, 2 or 3 = pin 0.
- R8: Mode register 0 bits [5:4] pick counter 3's source: 0 = /16, 1 = `slow_tick_i` undivided, 2 or 3 = pin 1. Mode register 1 bits [1:0] pick counter 4's source: 0 = /16, 1 = /2, 2 = `slow_tick_i`, 3 = counter 3 overflow.
- R9: Mode register 1 bits [3:2] pick counter 5's source: 0 = /16, 1 = counter 2 overflow, 2 or 3 = counter 4 overflow. Bit [4] picks counter 6's source: 0 = /16, 1 = counter 5 overflow. A chained overflow reaches the next counter in the same cycle.
- R10: Each external pin passes through two synchronising flops. A high-to-low transition becomes one count pulse in the cycle that follows the second clock edge at which the pin is sampled low.
- R11: A request bit is set in the cycle after its counter overflows and stays set until a 1 is written to its bit of `irq_clr_i`. Setting wins over clearing in the same cycle.
- R12: A mode write changes only the register that `mode_idx_i` selects. Bits 7:6 of register 0 and bits 7:5 of register 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fast_tick_i | input | 1 | One-cycle enable from the fast oscillator |
| slow_tick_i | input | 1 | One-cycle enable from the slow oscillator |
| base_sel_i | input | 1 | Prescaler base: 0 fast, 1 slow |
| ext_pin_i | input | 2 | External count pins, idle high |
| lat_we_i | input | 1 | Latch write strobe |
| lat_idx_i | input | 3 | Counter index for a latch write |
| wr_data_i | input | 8 | Write data for latches and mode registers |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_idx_i | input | 1 | Mode register select |
| irq_clr_i | input | 6 | Write-one-to-clear strobes for request bits |
| irq_o | output | 6 | Sticky interrupt request bits, bit k for counter k+1 |
| ovf_o | output | 6 | One-cycle overflow pulses, bit k for counter k+1 |

## Verification
Every cycle, the assertions check the per-counter arithmetic: a load takes effect at once, a count pulse decrements the counter, and a wrap at zero reloads it. They also check that request bits set, hold and clear as required, that the prescaler taps nest inside one another, and that a pin edge never yields two pulses in a row. The source-select encodings, the base-select choice and the chaining of overflows between counters can only be shown by the bench's scenarios. So can the exact division ratios over a window and the latency from pin to count. The bench shows them by comparing every cycle against a reference model and by counting overflows over windows of known length.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_N   = 6;
  localparam int unsigned TMR_DW  = 8;
  localparam int unsigned PRE_W   = 12;
  localparam int unsigned MID_W   = 4;
  localparam int unsigned EXT_N   = 2;
  localparam int unsigned IDX_W   = $clog2(TMR_N);
  localparam int unsigned MODE0_W = 6;
  localparam int unsigned MODE1_W = 5;

  // source codes shared by the selectors
  localparam logic [1:0] SRC_D16  = 2'd0;
  localparam logic [1:0] SRC_ALT1 = 2'd1;
  localparam logic [1:0] SRC_ALT2 = 2'd2;
  localparam logic [1:0] SRC_ALT3 = 2'd3;

  typedef struct packed {
    logic d2;
    logic d16;
    logic d4096;
  } tap_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned PW = PRE_W,
  parameter int unsigned MW = MID_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick_i,
  input  logic slow_tick_i,
  input  logic base_sel_i,
  output tap_t taps_o
);
  logic [PW-1:0] pre_q, pre_d;
  logic          base_tick;

  always_comb begin
    base_tick = base_sel_i ? slow_tick_i : fast_tick_i;
    pre_d     = pre_q;
    if (base_tick) pre_d = pre_q + 1'b1;
    taps_o.d2    = base_tick & pre_q[0];
    taps_o.d16   = base_tick & (&pre_q[MW-1:0]);
    taps_o.d4096 = base_tick & (&pre_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_TAP_NEST16: assert property (@(posedge clk) disable iff (!rst_n)
    taps_o.d4096 |-> taps_o.d16) else $error("tap nesting");  // R6
  AST_TAP_NEST2: assert property (@(posedge clk) disable iff (!rst_n)
    taps_o.d16 |-> taps_o.d2) else $error("tap nesting");  // R6
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_tick_i && !slow_tick_i) |=> $stable(pre_q)) else $error("prescaler moved");  // R5
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
  import tmr_pkg::*;
#(
  parameter int unsigned N = EXT_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign fall_o[g] = prev_q & ~s2_q;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[g] |=> !fall_o[g]) else $error("double edge pulse");  // R10
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned DW = TMR_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          clr_i,
  output logic          ovf_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, cnt_d, lat_q, lat_d;
  logic          irq_q, irq_d;
  logic          at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    ovf_o   = tick_i & ~load_i & at_zero;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    if (load_i) begin
      cnt_d = load_val_i;
      lat_d = load_val_i;
    end else if (tick_i) begin
      cnt_d = at_zero ? lat_q : cnt_q - 1'b1;
    end
    irq_d = ovf_o | (irq_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)) && (lat_q == $past(load_val_i))) else $error("load");  // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1) else $error("decrement");  // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q == '0) |=> cnt_q == $past(lat_q)) else $error("reload");  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q)) else $error("idle move");  // R3
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> irq_o) else $error("irq set");  // R11
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ovf_o) |=> !irq_o) else $error("irq clear");  // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o) else $error("irq hold");  // R11
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned DW   = TMR_DW,
  parameter int unsigned PW   = PRE_W,
  parameter int unsigned NEXT = EXT_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic             base_sel_i,
  input  logic [NEXT-1:0]  ext_pin_i,
  input  logic             lat_we_i,
  input  logic [IDX_W-1:0] lat_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             mode_we_i,
  input  logic             mode_idx_i,
  input  logic [TMR_N-1:0] irq_clr_i,
  output logic [TMR_N-1:0] irq_o,
  output logic [TMR_N-1:0] ovf_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // mode registers
  logic [MODE0_W-1:0] mode0_q, mode0_d;
  logic [MODE1_W-1:0] mode1_q, mode1_d;

  always_comb begin
    mode0_d = mode0_q;
    mode1_d = mode1_q;
    if (mode_we_i) begin
      if (mode_idx_i) mode1_d = wr_data_i[MODE1_W-1:0];
      else            mode0_d = wr_data_i[MODE0_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode0_q <= '0;
      mode1_q <= '0;
    end else begin
      mode0_q <= mode0_d;
      mode1_q <= mode1_d;
    end
  end

  // shared sources
  tap_t            taps;
  logic [NEXT-1:0] ext_fall;

  tmr_prescale #(.PW(PW), .MW(MID_W)) u_pre (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .base_sel_i  (base_sel_i),
    .taps_o      (taps)
  );

  tmr_edge_sync #(.N(NEXT)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_i  (ext_pin_i),
    .fall_o (ext_fall)
  );

  // per-counter load strobes
  logic [TMR_N-1:0] load;
  always_comb begin
    load = '0;
    for (int k = 0; k < TMR_N; k++)
      if (lat_we_i && (lat_idx_i == IDX_W'(k))) load[k] = 1'b1;
  end

  // source selection, written as separate scalars so the chain stays acyclic
  logic tk1, tk2, tk3, tk4, tk5, tk6;
  logic of1, of2, of3, of4, of5, of6;
  logic [1:0] sel1, sel2, sel3, sel4, sel5;

  assign sel1 = mode0_q[1:0];
  assign sel2 = mode0_q[3:2];
  assign sel3 = mode0_q[5:4];
  assign sel4 = mode1_q[1:0];
  assign sel5 = mode1_q[3:2];

  always_comb begin
    case (sel1)
      SRC_D16:  tk1 = taps.d16;
      SRC_ALT1: tk1 = taps.d4096;
      default:  tk1 = ext_fall[0];
    endcase
  end

  always_comb begin
    case (sel2)
      SRC_D16:  tk2 = taps.d16;
      SRC_ALT1: tk2 = of1;
      default:  tk2 = ext_fall[0];
    endcase
  end

  always_comb begin
    case (sel3)
      SRC_D16:  tk3 = taps.d16;
      SRC_ALT1: tk3 = slow_tick_i;
      default:  tk3 = ext_fall[NEXT-1];
    endcase
  end

  always_comb begin
    case (sel4)
      SRC_D16:  tk4 = taps.d16;
      SRC_ALT1: tk4 = taps.d2;
      SRC_ALT2: tk4 = slow_tick_i;
      default:  tk4 = of3;
    endcase
  end

  always_comb begin
    case (sel5)
      SRC_D16:  tk5 = taps.d16;
      SRC_ALT1: tk5 = of2;
      default:  tk5 = of4;
    endcase
  end

  assign tk6 = mode1_q[4] ? of5 : taps.d16;

  tmr_unit #(.DW(DW)) u_t1 (.clk(clk), .rst_n(rst_int_n), .tick_i(tk1), .load_i(load[0]),
    .load_val_i(wr_data_i), .clr_i(irq_clr_i[0]), .ovf_o(of1), .irq_o(irq_o[0]));
  tmr_unit #(.DW(DW)) u_t2 (.clk(clk), .rst_n(rst_int_n), .tick_i(tk2), .load_i(load[1]),
    .load_val_i(wr_data_i), .clr_i(irq_clr_i[1]), .ovf_o(of2), .irq_o(irq_o[1]));
  tmr_unit #(.DW(DW)) u_t3 (.clk(clk), .rst_n(rst_int_n), .tick_i(tk3), .load_i(load[2]),
    .load_val_i(wr_data_i), .clr_i(irq_clr_i[2]), .ovf_o(of3), .irq_o(irq_o[2]));
  tmr_unit #(.DW(DW)) u_t4 (.clk(clk), .rst_n(rst_int_n), .tick_i(tk4), .load_i(load[3]),
    .load_val_i(wr_data_i), .clr_i(irq_clr_i[3]), .ovf_o(of4), .irq_o(irq_o[3]));
  tmr_unit #(.DW(DW)) u_t5 (.clk(clk), .rst_n(rst_int_n), .tick_i(tk5), .load_i(load[4]),
    .load_val_i(wr_data_i), .clr_i(irq_clr_i[4]), .ovf_o(of5), .irq_o(irq_o[4]));
  tmr_unit #(.DW(DW)) u_t6 (.clk(clk), .rst_n(rst_int_n), .tick_i(tk6), .load_i(load[5]),
    .load_val_i(wr_data_i), .clr_i(irq_clr_i[5]), .ovf_o(of6), .irq_o(irq_o[5]));

  assign ovf_o = {of6, of5, of4, of3, of2, of1};

  AST_MODE_SEL0: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_we_i && mode_idx_i) |=> $stable(mode0_q)) else $error("mode0 touched");  // R12
  AST_MODE_SEL1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_we_i && !mode_idx_i) |=> $stable(mode1_q)) else $error("mode1 touched");  // R12
  AST_OVF_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fast_tick_i && !slow_tick_i && ext_fall == '0) |-> ovf_o == '0) else $error("ovf idle");  // R4
endmodule

// File: tb/timer_bank_bench.sv
`timescale 1ns/1ps
module timer_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fast, slow, bsel;
  logic [1:0] pins;
  logic       lwe, mwe, midx;
  logic [2:0] lidx;
  logic [7:0] wdata;
  logic [5:0] clr;
  logic [5:0] irq, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ovf_cnt [6];

  // reference model state
  logic [11:0] m_pre;
  logic [1:0]  m_s1, m_s2, m_prev;
  logic [7:0]  m_cnt [6];
  logic [7:0]  m_lat [6];
  logic [5:0]  m_irq;
  logic [5:0]  m_ma;
  logic [4:0]  m_mb;

  always #2.5 clk = ~clk;

  timer_bank u_timer_bank (
    .clk(clk), .rst_n(rst_n), .fast_tick_i(fast), .slow_tick_i(slow), .base_sel_i(bsel),
    .ext_pin_i(pins), .lat_we_i(lwe), .lat_idx_i(lidx), .wr_data_i(wdata),
    .mode_we_i(mwe), .mode_idx_i(midx), .irq_clr_i(clr), .irq_o(irq), .ovf_o(ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pick(input int i, input logic t2, input logic t16, input logic t4k,
                                input logic [1:0] fall, input logic [5:0] ov);
    case (i)
      0: return (m_ma[1:0] == 0) ? t16 : (m_ma[1:0] == 1) ? t4k : fall[0];
      1: return (m_ma[3:2] == 0) ? t16 : (m_ma[3:2] == 1) ? ov[0] : fall[0];
      2: return (m_ma[5:4] == 0) ? t16 : (m_ma[5:4] == 1) ? slow : fall[1];
      3: return (m_mb[1:0] == 0) ? t16 : (m_mb[1:0] == 1) ? t2 : (m_mb[1:0] == 2) ? slow : ov[2];
      4: return (m_mb[3:2] == 0) ? t16 : (m_mb[3:2] == 1) ? ov[1] : ov[3];
      default: return m_mb[4] ? ov[4] : t16;
    endcase
  endfunction

  // one cycle: compare outputs with the model, then advance both
  task automatic step();
    logic base, t2, t16, t4k;
    logic [1:0] fall;
    logic [5:0] tk, ov, hit;
    #1;
    base = bsel ? slow : fast;                       // R5
    t2   = base & m_pre[0];                          // R6
    t16  = base & (m_pre[3:0] == 4'hF);
    t4k  = base & (m_pre == 12'hFFF);
    fall = m_prev & ~m_s2;                           // R10
    ov = '0; tk = '0; hit = '0;
    for (int i = 0; i < 6; i++) begin
      hit[i] = lwe && (lidx == 3'(i));
      tk[i]  = pick(i, t2, t16, t4k, fall, ov);
      ov[i]  = tk[i] & ~hit[i] & (m_cnt[i] == 8'h00);
    end
    check(ovf === ov, "R4 ovf pulses", ovf, ov);
    check(irq === m_irq, "R11 request bits", irq, m_irq);
    for (int i = 0; i < 6; i++) ovf_cnt[i] += int'(ovf[i]);
    for (int i = 0; i < 6; i++) begin
      if (hit[i]) begin
        m_cnt[i] = wdata; m_lat[i] = wdata;
      end else if (tk[i]) begin
        m_cnt[i] = (m_cnt[i] == 8'h00) ? m_lat[i] : m_cnt[i] - 8'd1;
      end
    end
    m_irq  = ov | (m_irq & ~clr);
    m_pre  = m_pre + 12'(base);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    if (mwe) begin
      if (midx) m_mb = wdata[4:0];
      else      m_ma = wdata[5:0];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic zero_counts();
    for (int i = 0; i < 6; i++) ovf_cnt[i] = 0;
  endtask

  task automatic wr_lat(input int idx, input int val);
    lwe = 1'b1; lidx = 3'(idx); wdata = 8'(val);
    step();
    lwe = 1'b0;
  endtask

  task automatic wr_mode(input bit sel, input int val);
    mwe = 1'b1; midx = sel; wdata = 8'(val);
    step();
    mwe = 1'b0;
  endtask

  task automatic idle();
    fast = 0; slow = 0; bsel = 0; clr = '0; lwe = 0; mwe = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pins = 2'b11; midx = 0; lidx = 0; wdata = 0;
    idle();
    m_pre = '0; m_s1 = 2'b11; m_s2 = 2'b11; m_prev = 2'b11;
    m_irq = '0; m_ma = '0; m_mb = '0;
    for (int i = 0; i < 6; i++) begin m_cnt[i] = '0; m_lat[i] = '0; end
    zero_counts();
    repeat (3) @(negedge clk);
    #1;
    check(irq == 6'h00, "R1 reset irq", irq, 0);
    check(ovf == 6'h00, "R1 reset ovf", ovf, 0);
    rst_n = 1;
    run(4);

    // R3: divide by n+1 on the /16 tap
    wr_mode(0, 8'h00); wr_mode(1, 8'h00); wr_lat(0, 3);
    zero_counts(); fast = 1; run(640); fast = 0;
    check(ovf_cnt[0] == 10, "R3 T1 latch 3 over 40 ticks", ovf_cnt[0], 10);

    // R2: latch write reloads the live counter at once
    wr_mode(0, 8'h10); wr_lat(2, 200);
    slow = 1; run(5); slow = 0;
    wr_lat(2, 2);
    zero_counts(); slow = 1; run(2);
    check(ovf_cnt[2] == 0, "R2 no early overflow after reload", ovf_cnt[2], 0);
    run(1); slow = 0;
    check(ovf_cnt[2] == 1, "R2 overflow on third pulse after write", ovf_cnt[2], 1);

    // R6: /2 and /4096 taps
    wr_mode(0, 8'h01); wr_mode(1, 8'h01); wr_lat(3, 1); wr_lat(0, 0);
    zero_counts(); fast = 1; run(640);
    check(ovf_cnt[3] == 160, "R6 /2 tap into T4", ovf_cnt[3], 160);
    zero_counts(); run(8192 - 640); run(640); fast = 0;
    check(ovf_cnt[0] == 2, "R6 /4096 tap into T1", ovf_cnt[0], 2);

    // R5: base select
    wr_mode(0, 8'h00); wr_lat(0, 3);
    bsel = 1; zero_counts(); fast = 1; run(200); fast = 0;
    check(ovf_cnt[0] == 0, "R5 fast ignored when slow selected", ovf_cnt[0], 0);
    wr_lat(0, 3); bsel = 1;
    zero_counts(); slow = 1; run(640); slow = 0; bsel = 0;
    check(ovf_cnt[0] == 10, "R5 slow drives prescaler", ovf_cnt[0], 10);

    // R7: T2 chained from T1
    wr_mode(0, 8'h04); wr_lat(0, 0); wr_lat(1, 3);
    zero_counts(); fast = 1; run(640); fast = 0;
    check(ovf_cnt[0] == 40, "R7 T1 every /16 tick", ovf_cnt[0], 40);
    check(ovf_cnt[1] == 10, "R7 T2 from T1 overflow", ovf_cnt[1], 10);

    // R8 / R9: T3 -> T4 -> T5 -> T6 chain from the slow tick
    wr_mode(0, 8'h10); wr_mode(1, 8'h1B);
    wr_lat(2, 4); wr_lat(3, 9); wr_lat(4, 0); wr_lat(5, 1);
    zero_counts(); slow = 1; run(500); slow = 0;
    check(ovf_cnt[2] == 100, "R8 T3 from slow tick", ovf_cnt[2], 100);
    check(ovf_cnt[3] == 10, "R8 T4 from T3 overflow", ovf_cnt[3], 10);
    check(ovf_cnt[4] == 10, "R9 T5 from T4 overflow", ovf_cnt[4], 10);
    check(ovf_cnt[5] == 5, "R9 T6 from T5 overflow", ovf_cnt[5], 5);

    // R10: external pin falling edges
    clr = 6'h3F; step(); clr = '0;
    wr_mode(0, 8'h02); wr_lat(0, 0);
    zero_counts();
    for (int e = 0; e < 20; e++) begin
      pins[0] = 0; run(4); pins[0] = 1; run(4);
    end
    run(4);
    check(ovf_cnt[0] == 20, "R10 one pulse per falling edge", ovf_cnt[0], 20);

    // R11: sticky request, write-one-to-clear
    run(3);
    check(irq[0] == 1'b1, "R11 request held", int'(irq[0]), 1);
    clr = 6'h01; step(); clr = '0;
    check(irq[0] == 1'b0, "R11 request cleared", int'(irq[0]), 0);

    // R12: writing mode register 1 leaves T1 on the idle pin
    wr_mode(1, 8'hFF);
    zero_counts(); fast = 1; run(200); fast = 0;
    check(ovf_cnt[0] == 0, "R12 mode 1 write leaves T1 source", ovf_cnt[0], 0);

    // constrained random mix, checked every cycle by the model
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      fast = 1'($urandom % 2);
      slow = 1'(($urandom % 6) == 0);
      if (($urandom % 64) == 0) bsel = ~bsel;
      if (($urandom % 5) == 0) pins = 2'($urandom);
      lwe = 1'(($urandom % 12) == 0);
      lidx = 3'($urandom % 8);
      mwe = 1'(($urandom % 40) == 0);
      midx = 1'($urandom % 2);
      wdata = lwe ? 8'($urandom % 6) : 8'($urandom);
      clr = (($urandom % 8) == 0) ? 6'($urandom) : 6'h00;
      step();
    end
    idle();
    run(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule